// File: doc/BRIEF.md
# Looping sample playback voice

This block is one voice of a wavetable sound generator. Software programs a 21-bit waveform base address, a loop start and a loop end (both counted in samples from the base), a sample format and a loop enable through four 16-bit registers. These registers sit on 32-bit aligned addresses. Writing a key event into the control register starts or stops the voice. While the voice plays, every one-cycle `sample_tick` makes it issue one byte-addressed read to sample memory. One cycle later it presents the fetched sample on `sample_out` with a `sample_valid` strobe.

In one-shot mode the voice plays from position 0 up to and including the loop-end sample, then falls idle. In loop mode it wraps from the loop end back to the loop start. A key-off given to a looping voice does not silence it. The voice is only released, and stops when software later clears the loop bit. A controller can poll `voice_active` to detect the end of playback. The 4-bit compressed formats are stepped at half a byte per sample, and their raw codes are handed on undecoded.

Register map (byte offsets; address bits [1:0] are ignored): 0x0 control, 0x4 base address low 16 bits, 0x8 loop start, 0xC loop end. Control fields: [1:0] key event, [2] loop enable, [5:4] format, [12:8] base address bits 20..16. All other bits are reserved.

Top module: `wt_voice`

## Requirements
- R1: After reset every register reads zero. Each register reads back what was last written to it, with bits [31:16] of `reg_rdata` always zero. In the control register the key-event field [1:0] and the reserved bits read as zero.
- R2: A control write with key code 3 (binary 11) sets `voice_active` in the cycle after the write, and restarts playback at sample position 0, including when the voice is already playing.
- R3: A control write with key code 0 or 1 leaves the active state and the sample position unchanged.
- R4: The read address for sample position p is base + 2p for format 0 (16-bit), base + p for format 1 (8-bit), and base + floor(p/2) for formats 2 and 3 (4-bit), all modulo 2^21. For formats 2 and 3, `mem_nibble` equals bit 0 of p.
- R5: A tick seen while active gives one `mem_rd` pulse in the next cycle and `sample_valid` one cycle after that. `sample_out` is then `mem_rdata` for format 0, {`mem_rdata`[7:0], 8'h00} for format 1, and the selected nibble of `mem_rdata`[7:0] (low nibble for even p, high for odd) in bits [3:0] for formats 2 and 3. Otherwise `sample_out` is zero.
- R6: With the loop bit clear, the voice fetches the loop-end sample and then drops `voice_active` in the same cycle as that `mem_rd`.
- R7: With the loop bit set, the position after the loop-end sample is the loop start.
- R8: A key-off (code 2, binary 10) written with the loop bit clear drops `voice_active` in the cycle after the write.
- R9: A key-off written with the loop bit set keeps the voice playing. A later control write that clears the loop bit then drops `voice_active` in the next cycle.
- R10: Clearing the loop bit on a voice that has not been keyed off does not stop it at once. It plays on to the loop end and stops there.
- R11: While `voice_active` is low, ticks produce no `mem_rd` and no `sample_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W (4) | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| sample_tick | input | 1 | One-cycle pulse requesting the next sample |
| mem_rd | output | 1 | Sample memory read strobe |
| mem_addr | output | ADDR_W (21) | Sample memory byte address |
| mem_nibble | output | 1 | Nibble select for 4-bit formats |
| mem_rdata | input | DATA_W (16) | Memory data, valid the cycle after `mem_rd` |
| sample_out | output | DATA_W (16) | Formatted sample, zero when not valid |
| sample_valid | output | 1 | Marks a fetched sample on `sample_out` |
| voice_active | output | 1 | Voice is playing |

## Verification
The sequencer is driven through one-shot and looping runs in each of the four formats. Walking the positions across the loop end shows whether the voice stops or wraps. Odd base addresses and a base near the top of the address space show whether the address scaling and the 21-bit wrap are right per format. In the 4-bit formats, alternating nibble positions tell a wrong nibble select apart from a wrong byte step. Key events are tried in every combination with the loop bit, and also as neutral codes 0 and 1. These combinations separate an immediate stop, a release that waits for the loop bit to clear, and a play-to-end after the loop bit is cleared. Random runs mix bases, loop windows, formats and mid-play stop events against a bench model built from the requirements.

// File: rtl/wtv_pkg.sv
package wtv_pkg;

  typedef enum logic {
    V_IDLE = 1'b0,
    V_PLAY = 1'b1
  } vstate_t;

  typedef enum logic [1:0] {
    F_PCM16    = 2'd0,
    F_PCM8     = 2'd1,
    F_NIB      = 2'd2,
    F_NIB_LOOP = 2'd3
  } fmt_t;

  localparam logic [1:0] KEY_ON  = 2'b11;
  localparam logic [1:0] KEY_OFF = 2'b10;

  localparam logic [1:0] W_CTRL   = 2'd0;
  localparam logic [1:0] W_BASE   = 2'd1;
  localparam logic [1:0] W_LSTART = 2'd2;
  localparam logic [1:0] W_LEND   = 2'd3;

  localparam int B_KEY  = 0;
  localparam int B_LOOP = 2;
  localparam int B_FMT  = 4;
  localparam int B_HI   = 8;

endpackage

// File: rtl/wtv_regs.sv
module wtv_regs
  import wtv_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int REG_W  = 16,
  parameter int RA_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [RA_W-1:0]   addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [ADDR_W-1:0] base,
  output logic [REG_W-1:0]  lp_start,
  output logic [REG_W-1:0]  lp_end,
  output logic              loop_en,
  output fmt_t              fmt,
  output logic              key_on,
  output logic              key_off,
  output logic              ctrl_wr,
  output logic              wr_loop
);

  localparam int HI_W = ADDR_W - REG_W;

  logic [1:0]       word;
  logic [HI_W-1:0]  base_hi_q;
  logic [REG_W-1:0] base_lo_q;
  logic [REG_W-1:0] ls_q;
  logic [REG_W-1:0] le_q;
  logic             loop_q;
  fmt_t             fmt_q;
  logic             base_we, ls_we, le_we;
  logic             unused_bits;

  assign word    = addr[3:2];
  assign ctrl_wr = wr && (word == W_CTRL);
  assign base_we = wr && (word == W_BASE);
  assign ls_we   = wr && (word == W_LSTART);
  assign le_we   = wr && (word == W_LEND);
  assign wr_loop = wdata[B_LOOP];
  assign key_on  = ctrl_wr && (wdata[B_KEY+:2] == KEY_ON);
  assign key_off = ctrl_wr && (wdata[B_KEY+:2] == KEY_OFF);

  assign unused_bits = ^{addr[1:0], wdata[31:REG_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi_q <= '0;
      loop_q    <= 1'b0;
      fmt_q     <= F_PCM16;
    end else if (ctrl_wr) begin
      base_hi_q <= wdata[B_HI+:HI_W];
      loop_q    <= wdata[B_LOOP];
      fmt_q     <= fmt_t'(wdata[B_FMT+:2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_lo_q <= '0;
    else if (base_we) base_lo_q <= wdata[REG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ls_q <= '0;
    else if (ls_we) ls_q <= wdata[REG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     le_q <= '0;
    else if (le_we) le_q <= wdata[REG_W-1:0];
  end

  always_comb begin
    rdata = '0;
    unique case (word)
      W_CTRL: begin
        rdata[B_HI+:HI_W] = base_hi_q;
        rdata[B_LOOP]     = loop_q;
        rdata[B_FMT+:2]   = fmt_q;
      end
      W_BASE:   rdata[REG_W-1:0] = base_lo_q;
      W_LSTART: rdata[REG_W-1:0] = ls_q;
      W_LEND:   rdata[REG_W-1:0] = le_q;
    endcase
  end

  assign base     = {base_hi_q, base_lo_q};
  assign lp_start = ls_q;
  assign lp_end   = le_q;
  assign loop_en  = loop_q;
  assign fmt      = fmt_q;

endmodule

// File: rtl/wtv_fsm.sv
module wtv_fsm
  import wtv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic key_on,
  input  logic key_off,
  input  logic ctrl_wr,
  input  logic wr_loop,
  input  logic tick,
  input  logic at_end,
  input  logic loop_en,
  output logic active,
  output logic issue
);

  vstate_t st_q, st_n;
  logic    rel_q, rel_n;

  always_comb begin
    st_n  = st_q;
    rel_n = rel_q;
    issue = 1'b0;
    if (key_on) begin
      st_n  = V_PLAY;
      rel_n = 1'b0;
    end else if (key_off && st_q == V_PLAY) begin
      if (!wr_loop) begin
        st_n  = V_IDLE;
        rel_n = 1'b0;
      end else begin
        rel_n = 1'b1;
      end
    end else if (ctrl_wr && !wr_loop && rel_q && st_q == V_PLAY) begin
      st_n  = V_IDLE;
      rel_n = 1'b0;
    end else if (tick && st_q == V_PLAY) begin
      issue = 1'b1;
      if (at_end && !loop_en) begin
        st_n  = V_IDLE;
        rel_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= V_IDLE;
      rel_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      rel_q <= rel_n;
    end
  end

  assign active = (st_q == V_PLAY);

endmodule

// File: rtl/wtv_addr.sv
module wtv_addr
  import wtv_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int POS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              issue,
  input  logic [ADDR_W-1:0] base,
  input  logic [POS_W-1:0]  lp_start,
  input  logic [POS_W-1:0]  lp_end,
  input  logic              loop_en,
  input  fmt_t              fmt,
  output logic              at_end,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_nib,
  output fmt_t              fmt_rd
);

  localparam int OFF_W = POS_W + 1;

  logic [POS_W-1:0]  pos_q, pos_n;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] addr_n;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              nib_q;
  fmt_t              fmt_q;

  assign at_end = (pos_q == lp_end);

  always_comb begin
    unique case (fmt)
      F_PCM16: off = {pos_q, 1'b0};
      F_PCM8:  off = {1'b0, pos_q};
      default: off = {2'b00, pos_q[POS_W-1:1]};
    endcase
  end

  assign addr_n = base + ADDR_W'(off);

  always_comb begin
    pos_n = pos_q;
    if (restart)
      pos_n = '0;
    else if (issue)
      pos_n = at_end ? (loop_en ? lp_start : pos_q) : pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      nib_q  <= 1'b0;
      fmt_q  <= F_PCM16;
    end else if (issue) begin
      addr_q <= addr_n;
      nib_q  <= pos_q[0];
      fmt_q  <= fmt;
    end
  end

  assign mem_rd   = rd_q;
  assign mem_addr = addr_q;
  assign mem_nib  = nib_q;
  assign fmt_rd   = fmt_q;

endmodule

// File: rtl/wtv_fmt.sv
module wtv_fmt
  import wtv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_rd,
  input  logic              nib,
  input  fmt_t              fmt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] sample,
  output logic              valid
);

  logic valid_q;
  logic nib_q;
  fmt_t fmt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= mem_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_q <= 1'b0;
      fmt_q <= F_PCM16;
    end else if (mem_rd) begin
      nib_q <= nib;
      fmt_q <= fmt;
    end
  end

  always_comb begin
    sample = '0;
    if (valid_q) begin
      unique case (fmt_q)
        F_PCM16: sample = mem_rdata;
        F_PCM8:  sample = {mem_rdata[7:0], {(DATA_W-8){1'b0}}};
        default: sample[3:0] = nib_q ? mem_rdata[7:4] : mem_rdata[3:0];
      endcase
    end
  end

  assign valid = valid_q;

endmodule

// File: rtl/wt_voice.sv
module wt_voice
  import wtv_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int RA_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              sample_tick,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_nibble,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] sample_out,
  output logic              sample_valid,
  output logic              voice_active
);

  localparam int REG_W = 16;
  localparam int POS_W = REG_W;

  logic [ADDR_W-1:0] base;
  logic [POS_W-1:0]  lp_start, lp_end;
  logic              loop_en, key_on, key_off, ctrl_wr, wr_loop;
  logic              at_end, issue;
  fmt_t              fmt, fmt_rd;

  wtv_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .base(base),
    .lp_start(lp_start), .lp_end(lp_end), .loop_en(loop_en), .fmt(fmt),
    .key_on(key_on), .key_off(key_off), .ctrl_wr(ctrl_wr), .wr_loop(wr_loop)
  );

  wtv_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .key_on(key_on), .key_off(key_off),
    .ctrl_wr(ctrl_wr), .wr_loop(wr_loop), .tick(sample_tick),
    .at_end(at_end), .loop_en(loop_en), .active(voice_active), .issue(issue)
  );

  wtv_addr #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .restart(key_on), .issue(issue),
    .base(base), .lp_start(lp_start), .lp_end(lp_end), .loop_en(loop_en),
    .fmt(fmt), .at_end(at_end), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_nib(mem_nibble), .fmt_rd(fmt_rd)
  );

  wtv_fmt #(.DATA_W(DATA_W)) u_fmt (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .nib(mem_nibble),
    .fmt(fmt_rd), .mem_rdata(mem_rdata), .sample(sample_out),
    .valid(sample_valid)
  );

endmodule

// File: rtl/wt_voice_chk.sv
module wt_voice_chk #(
  parameter int DATA_W = 16,
  parameter int RA_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [RA_W-1:0]   reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              mem_rd,
  input logic [DATA_W-1:0] sample_out,
  input logic              sample_valid,
  input logic              voice_active
);

  logic ctrl_w;
  assign ctrl_w = reg_wr && (reg_addr[3:2] == 2'd0);

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:16] == 16'h0);

  p_keyon_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_w && reg_wdata[1:0] == 2'b11) |=> voice_active);

  p_valid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> sample_valid);

  p_valid_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(mem_rd));

  p_quiet_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> (sample_out == '0));

  p_keyoff_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_w && reg_wdata[1:0] == 2'b10 && !reg_wdata[2]) |=> !voice_active);

  p_idle_no_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> $past(voice_active));

endmodule

bind wt_voice wt_voice_chk #(.DATA_W(DATA_W), .RA_W(RA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
  .sample_out(sample_out), .sample_valid(sample_valid),
  .voice_active(voice_active)
);

// File: tb/test_wt_voice.sv
`timescale 1ns/1ps
module test_wt_voice;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        sample_tick;
  logic        mem_rd;
  logic [20:0] mem_addr;
  logic        mem_nibble;
  logic [15:0] mem_rdata;
  logic [15:0] sample_out;
  logic        sample_valid;
  logic        voice_active;

  int vecs = 0;
  int errs = 0;

  logic [20:0] m_base;
  logic [1:0]  m_fmt;
  logic        m_loop;
  logic [15:0] m_ls, m_le, m_pos;
  logic        m_act, m_rel;

  always #2 clk = ~clk;

  wt_voice i_wt_voice (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sample_tick(sample_tick),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_nibble(mem_nibble),
    .mem_rdata(mem_rdata), .sample_out(sample_out),
    .sample_valid(sample_valid), .voice_active(voice_active)
  );

  function automatic logic [7:0] pat(input logic [20:0] a);
    logic [20:0] t;
    t = (a * 21'd151) ^ (a >> 5);
    return t[7:0];
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= {pat(mem_addr + 21'd1), pat(mem_addr)};

  function automatic logic [20:0] exp_addr(input logic [15:0] p);
    case (m_fmt)
      2'd0:    return m_base + {4'd0, p, 1'b0};
      2'd1:    return m_base + {5'd0, p};
      default: return m_base + {6'd0, p[15:1]};
    endcase
  endfunction

  function automatic logic [15:0] exp_samp(input logic [20:0] a, input logic n);
    logic [7:0] b;
    b = pat(a);
    case (m_fmt)
      2'd0:    return {pat(a + 21'd1), b};
      2'd1:    return {b, 8'h00};
      default: return {12'h000, n ? b[7:4] : b[3:0]};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {w, 2'b00}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [1:0] w, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = {w, 2'b01};
    #1 check(tag, reg_rdata, exp);
  endtask

  task automatic ctrl(input string tag, input logic [1:0] key, input logic lp);
    logic [31:0] d;
    d = {19'd0, m_base[20:16], 2'b00, m_fmt, 1'b0, lp, key};
    wreg(2'd0, d);
    if (key == 2'b11) begin
      m_act = 1'b1; m_pos = '0; m_rel = 1'b0;
    end else if (key == 2'b10 && m_act) begin
      if (!lp) begin m_act = 1'b0; m_rel = 1'b0; end
      else m_rel = 1'b1;
    end else if (m_act && m_rel && !lp) begin
      m_act = 1'b0; m_rel = 1'b0;
    end
    m_loop = lp;
    check(tag, voice_active, m_act);
  endtask

  task automatic setup(input logic [20:0] b, input logic [1:0] f,
                       input logic [15:0] ls, input logic [15:0] le);
    m_base = b; m_fmt = f; m_ls = ls; m_le = le;
    wreg(2'd1, {16'd0, b[15:0]});
    wreg(2'd2, {16'd0, ls});
    wreg(2'd3, {16'd0, le});
  endtask

  task automatic do_tick(input string tag);
    logic [20:0] ea;
    logic [15:0] es;
    logic        en;
    en = m_act; ea = '0; es = '0;
    if (en) begin
      ea = exp_addr(m_pos);
      es = exp_samp(ea, m_pos[0]);
    end
    @(negedge clk) sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
    check({tag, " R5/R11 mem_rd"}, mem_rd, en);
    if (en) begin
      check({tag, " R4 mem_addr"}, mem_addr, ea);
      if (m_fmt[1]) check({tag, " R4 nibble"}, mem_nibble, m_pos[0]);
      if (m_pos == m_le) begin
        if (m_loop) m_pos = m_ls;
        else m_act = 1'b0;
      end else m_pos = m_pos + 16'd1;
    end
    check({tag, " R6/R7 active"}, voice_active, m_act);
    @(negedge clk);
    check({tag, " R5 valid"}, sample_valid, en);
    check({tag, " R5 sample"}, sample_out, en ? es : 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    sample_tick = 1'b0; mem_rdata = '0;
    m_base = '0; m_fmt = '0; m_loop = 1'b0; m_ls = '0; m_le = '0;
    m_pos = '0; m_act = 1'b0; m_rel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 reset active", voice_active, 1'b0);
    check("R1 reset mem_rd", mem_rd, 1'b0);
    check("R1 reset sample", {sample_valid, sample_out}, 17'h0);
    for (int w = 0; w < 4; w++) rchk("R1 reset reg", 2'(w), 32'h0);

    // R1 readback, key field reads zero, upper half zero
    wreg(2'd1, 32'hABCD_1234);
    wreg(2'd2, 32'hFFFF_0077);
    wreg(2'd3, 32'h0001_0099);
    wreg(2'd0, 32'hFFFF_FFFD);
    rchk("R1 ctrl readback", 2'd0, 32'h0000_1F34);
    rchk("R1 base readback", 2'd1, 32'h0000_1234);
    rchk("R1 lstart readback", 2'd2, 32'h0000_0077);
    rchk("R1 lend readback", 2'd3, 32'h0000_0099);
    check("R3 code1 no start", voice_active, 1'b0);

    // R11 ticks while idle
    do_tick("R11 idle");

    // R6 one-shot 8-bit
    setup(21'h00_0103, 2'd1, 16'd0, 16'd4);
    ctrl("R2 keyon 8b", 2'b11, 1'b0);
    for (int i = 0; i < 7; i++) do_tick("R6 oneshot8");

    // R7 loop 16-bit
    setup(21'h1A_0011, 2'd0, 16'd2, 16'd4);
    ctrl("R2 keyon 16b", 2'b11, 1'b1);
    for (int i = 0; i < 10; i++) do_tick("R7 loop16");
    // R3 neutral codes
    ctrl("R3 code0", 2'b00, 1'b1);
    do_tick("R3 after code0");
    ctrl("R3 code1", 2'b01, 1'b1);
    do_tick("R3 after code1");
    // R2 restart while playing
    ctrl("R2 restart", 2'b11, 1'b1);
    check("R2 restart pos", m_pos, 16'd0);
    do_tick("R2 restart tick");

    // R9 keyoff on looping voice
    ctrl("R9 keyoff loop", 2'b10, 1'b1);
    for (int i = 0; i < 6; i++) do_tick("R9 still playing");
    ctrl("R9 loop clear", 2'b00, 1'b0);
    check("R9 stopped", voice_active, 1'b0);
    do_tick("R9 idle");

    // R8 keyoff one-shot, 4-bit format odd base
    setup(21'h00_0F01, 2'd2, 16'd0, 16'd20);
    ctrl("R2 keyon 4b", 2'b11, 1'b0);
    for (int i = 0; i < 5; i++) do_tick("R4 nib");
    ctrl("R8 keyoff", 2'b10, 1'b0);
    check("R8 stopped", voice_active, 1'b0);
    do_tick("R8 idle");

    // R10 loop cleared without keyoff plays to end
    setup(21'h05_5555, 2'd3, 16'd1, 16'd5);
    ctrl("R2 keyon 4bl", 2'b11, 1'b1);
    for (int i = 0; i < 8; i++) do_tick("R10 loop");
    ctrl("R10 clear loop", 2'b00, 1'b0);
    check("R10 still active", voice_active, 1'b1);
    for (int i = 0; i < 8; i++) do_tick("R10 to end");
    check("R10 ended", voice_active, 1'b0);

    // R4 address wrap at top of space
    setup(21'h1F_FFFD, 2'd0, 16'd0, 16'd3);
    ctrl("R2 keyon wrap", 2'b11, 1'b0);
    for (int i = 0; i < 5; i++) do_tick("R4 wrap");

    // random runs
    for (int r = 0; r < 40; r++) begin
      logic [15:0] a, b;
      int n;
      a = 16'($urandom_range(0, 12));
      b = 16'($urandom_range(0, 12));
      if (a > b) begin logic [15:0] t; t = a; a = b; b = t; end
      setup(21'($urandom), 2'($urandom_range(0, 3)), a, b);
      ctrl("R2 rnd keyon", 2'b11, 1'($urandom_range(0, 1)));
      n = $urandom_range(3, 25);
      for (int i = 0; i < n; i++) begin
        case ($urandom_range(0, 9))
          0: ctrl("R8/R9 rnd keyoff", 2'b10, 1'($urandom_range(0, 1)));
          1: ctrl("R9/R10 rnd loop", 2'b00, 1'($urandom_range(0, 1)));
          default: do_tick("R4/R5 rnd");
        endcase
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule